// File: doc/BRIEF.md
# Write-Through Store Queue

This block sits between a write-through cache and a slow main memory. The processor writes each store into the cache. In the same cycle it offers the store to this queue as a word address, a data word and a per-byte enable mask. The queue holds up to four stores in arrival order. A drain sequencer writes them out one at a time over a request/acknowledge memory write port. While all slots are taken the queue drops its ready output, and this stalls the processor. The only exception is a cycle in which memory acknowledges the head entry, because that entry frees a slot on the same edge.

A read that misses the cache presents its word address on the lookup port. The queue answers in the same cycle from the entries still waiting to be drained. The answer is a hit flag, a merged data word and a mask of which bytes came from queued stores. When several queued stores cover the same byte, the most recent one supplies it. The merged bytes sit on top of whatever memory returns, so a read never sees data older than a store that is still pending.

The drain sequencer has two states. In `DR_IDLE` no write is offered. The *launch* transition moves it to `DR_WAIT` when the queue is non-empty or a store is being accepted. In `DR_WAIT` a write request stands on the memory port. The *retire* transition returns it to `DR_IDLE` when memory acknowledges the last queued entry and no new store arrives. Any other acknowledge keeps it in `DR_WAIT`, and the next entry is presented.

Top module: `wt_store_queue`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, `mem_req` is 0 and `ld_hit` is 0.
- R2: A store is accepted on a rising edge where `st_valid` and `st_ready` are both 1. Its address, data and 4-bit byte mask (bit b covers data bits 8b+7..8b) later appear unchanged on `mem_addr`, `mem_data`, `mem_be`.
- R3: With 4 entries held and `mem_ack` low, `st_ready` is 0. A store offered then is not taken and never reaches the memory port.
- R4: With 4 entries held and `mem_ack` high, `st_ready` is 1. A store accepted in that cycle replaces the retired head, so the queue is still full afterwards.
- R5: Stores reach the memory port strictly in acceptance order.
- R6: Only one write is outstanding. While `mem_req` is 1 and `mem_ack` is 0, the request and its address, data and mask hold steady into the next cycle. The head entry is retired on the edge where `mem_ack` is 1.
- R7: `mem_req` rises in the cycle after a store is accepted into an empty queue. It falls in the cycle after the last entry is acknowledged.
- R8: `ld_hit` is 1 when any queued entry's address equals `ld_addr`. For each byte, `ld_data` carries that byte from the newest matching entry whose mask covers it, and `ld_be` is the OR of the matching masks.
- R9: Entries already retired take no part in the lookup. With no match, `ld_hit` is 0 and `ld_be` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor offers a store |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte mask |
| st_ready | output | 1 | Store can be taken this cycle (low stalls the processor) |
| mem_req | output | 1 | Write request to memory |
| mem_addr | output | ADDR_W | Write word address |
| mem_data | output | DATA_W | Write data |
| mem_be | output | DATA_W/8 | Write byte mask |
| mem_ack | input | 1 | Memory accepted the current write |
| ld_addr | input | ADDR_W | Read-miss word address to look up |
| ld_hit | output | 1 | Some queued store matches `ld_addr` |
| ld_data | output | DATA_W | Merged forwarded bytes |
| ld_be | output | DATA_W/8 | Bytes supplied by queued stores |

## Verification
A wrong occupancy count shows up quickly. It appears at `st_ready` as a stall one entry too early or too late, within the cycle of the fourth accepted store. It also appears as `mem_req` falling while entries remain, or staying high after the last acknowledge. A misplaced read or write pointer has two symptoms. The drain order breaks at the first acknowledged entry, and the lookup merges the wrong bytes in the very cycle the address is presented. Stalled and retired stores are checked through the memory port and the lookup port, so a store that leaks in, or lingers after it is drained, is seen there.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
    typedef enum logic [0:0] {
        DR_IDLE = 1'b0,
        DR_WAIT = 1'b1
    } drain_state_t;
endpackage

// File: rtl/wsq_fifo.sv
module wsq_fifo #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          pop,
    input  logic [ADDR_W-1:0]             in_addr,
    input  logic [DATA_W-1:0]             in_data,
    input  logic [BE_W-1:0]               in_be,
    output logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
    output logic [DEPTH-1:0][BE_W-1:0]    ent_be,
    output logic [PTR_W-1:0]              rd_ptr,
    output logic [CNT_W-1:0]              occ
);
    logic [PTR_W-1:0] wr_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            if (push && !pop)      occ <= occ + 1'b1;
            else if (pop && !push) occ <= occ - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(g)) begin
                ent_addr[g] <= in_addr;
                ent_data[g] <= in_data;
                ent_be[g]   <= in_be;
            end
        end
    end
endmodule

// File: rtl/wsq_drain.sv
module wsq_drain
    import wsq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic have_data,
    input  logic last_one,
    input  logic push,
    input  logic mem_ack,
    output logic mem_req,
    output logic pop
);
    drain_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE: if (have_data || push)              state_d = DR_WAIT;  // launch
            DR_WAIT: if (mem_ack && last_one && !push)   state_d = DR_IDLE;  // retire
            default:                                     state_d = DR_IDLE;
        endcase
    end

    always_comb begin
        mem_req = (state_q == DR_WAIT);
        pop     = mem_req && mem_ack;
    end
endmodule

// File: rtl/wsq_fwd.sv
module wsq_fwd #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
    input  logic [DEPTH-1:0][BE_W-1:0]   ent_be,
    input  logic [PTR_W-1:0]             rd_ptr,
    input  logic [CNT_W-1:0]             occ,
    input  logic [ADDR_W-1:0]            ld_addr,
    output logic                         ld_hit,
    output logic [DATA_W-1:0]            ld_data,
    output logic [BE_W-1:0]              ld_be
);
    logic [PTR_W-1:0] idx;

    // Walk from oldest to newest so later matches overwrite earlier bytes.
    always_comb begin
        ld_hit  = 1'b0;
        ld_data = '0;
        ld_be   = '0;
        idx     = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = rd_ptr + PTR_W'(k);
            if (CNT_W'(k) < occ && ent_addr[idx] == ld_addr) begin
                ld_hit = 1'b1;
                for (int b = 0; b < BE_W; b++) begin
                    if (ent_be[idx][b]) begin
                        ld_data[b*8 +: 8] = ent_data[idx][b*8 +: 8];
                        ld_be[b]          = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wt_store_queue.sv
module wt_store_queue #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    output logic              st_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BE_W-1:0]   mem_be,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic [BE_W-1:0]   ld_be
);
    logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
    logic [DEPTH-1:0][DATA_W-1:0] ent_data;
    logic [DEPTH-1:0][BE_W-1:0]   ent_be;
    logic [PTR_W-1:0]             rd_ptr;
    logic [CNT_W-1:0]             occ;
    logic                         push;
    logic                         pop;

    // A slot freed by this cycle's acknowledge may be refilled on the same edge.
    assign st_ready = (occ != CNT_W'(DEPTH)) || pop;
    assign push     = st_valid && st_ready;

    wsq_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .in_addr(st_addr), .in_data(st_data), .in_be(st_be),
        .ent_addr(ent_addr), .ent_data(ent_data), .ent_be(ent_be),
        .rd_ptr(rd_ptr), .occ(occ)
    );

    wsq_drain u_drain (
        .clk(clk), .rst_n(rst_n),
        .have_data(occ != '0), .last_one(occ == CNT_W'(1)),
        .push(push), .mem_ack(mem_ack),
        .mem_req(mem_req), .pop(pop)
    );

    assign mem_addr = ent_addr[rd_ptr];
    assign mem_data = ent_data[rd_ptr];
    assign mem_be   = ent_be[rd_ptr];

    wsq_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fwd (
        .ent_addr(ent_addr), .ent_data(ent_data), .ent_be(ent_be),
        .rd_ptr(rd_ptr), .occ(occ), .ld_addr(ld_addr),
        .ld_hit(ld_hit), .ld_data(ld_data), .ld_be(ld_be)
    );
endmodule

// File: rtl/wsq_checker.sv
module wsq_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic [BE_W-1:0]   mem_be,
    input logic              ld_hit,
    input logic [CNT_W-1:0]  occ
);
    // R6
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

    // R3
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH) && !mem_ack) |-> !st_ready);

    // R4
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH) && mem_req && mem_ack && st_valid) |=> (occ == CNT_W'(DEPTH)));

    // R7
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && st_valid && st_ready) |=> mem_req);

    // R7
    req_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (occ != '0));

    // R9
    empty_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !ld_hit);
endmodule

bind wt_store_queue wsq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be), .ld_hit(ld_hit), .occ(occ)
);

// File: tb/wt_store_queue_test.sv
`timescale 1ns/100ps
module wt_store_queue_test;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BW = DW / 8;
    localparam int NV = 5;

    // Each vector: {address, data, byte mask}
    localparam logic [AW+DW+BW-1:0] VEC [NV] = '{
        {32'h0000_0010, 32'h1111_2222, 4'hF},
        {32'h0000_0020, 32'h3333_4444, 4'hF},
        {32'h0000_0010, 32'hAAAA_BBBB, 4'h3},
        {32'h0000_0030, 32'h5566_7788, 4'h6},
        {32'h0000_0050, 32'hCAFE_0001, 4'hF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [BW-1:0] st_be = '0;
    logic st_ready, mem_req, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic [BW-1:0] mem_be;
    logic [AW-1:0] ld_addr = '0;
    logic ld_hit;
    logic [DW-1:0] ld_data;
    logic [BW-1:0] ld_be;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wt_store_queue #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_ready(st_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
        .mem_ack(mem_ack),
        .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data), .ld_be(ld_be)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_vec(input int i);
        @(negedge clk);
        {st_addr, st_data, st_be} = VEC[i];
        st_valid = 1'b1;
        #1 chk("R2", "ready before accept", 64'(st_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic drain_vec(input int i);
        @(negedge clk);
        chk("R5", "req present", 64'(mem_req), 64'd1);
        chk("R5", "drain address", 64'(mem_addr), 64'(VEC[i][AW+DW+BW-1 -: AW]));
        chk("R2", "drain data", 64'(mem_data), 64'(VEC[i][DW+BW-1 -: DW]));
        chk("R2", "drain mask", 64'(mem_be), 64'(VEC[i][BW-1:0]));
        mem_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_ack = 1'b0;
    endtask

    task automatic lookup(input logic [AW-1:0] a, input logic h,
                          input logic [DW-1:0] d, input logic [BW-1:0] m, input string req);
        ld_addr = a;
        #1;
        chk(req, "lookup hit", 64'(ld_hit), 64'(h));
        chk(req, "lookup mask", 64'(ld_be), 64'(m));
        if (h) chk(req, "lookup data", 64'(ld_data), 64'(d));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "ready after reset", 64'(st_ready), 64'd1);
        chk("R1", "req after reset", 64'(mem_req), 64'd0);
        chk("R1", "hit after reset", 64'(ld_hit), 64'd0);

        // Fill four slots with the memory side silent.
        for (int i = 0; i < 4; i++) begin
            push_vec(i);
            if (i == 0) chk("R7", "req after first accept", 64'(mem_req), 64'd1);
        end
        #1 chk("R3", "ready when full", 64'(st_ready), 64'd0);

        // R3: a store offered while stalled must be dropped.
        st_addr = 32'h77; st_data = 32'hDEAD_BEEF; st_be = 4'hF; st_valid = 1'b1;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            chk("R3", "stall held", 64'(st_ready), 64'd0);
            chk("R6", "head held without ack", 64'(mem_addr), 64'h10);
        end
        st_valid = 1'b0;

        // R8 forwarding over queued entries, newest byte wins.
        lookup(32'h10, 1'b1, 32'h1111_BBBB, 4'hF, "R8");
        lookup(32'h30, 1'b1, 32'h0066_7700, 4'h6, "R8");
        lookup(32'h40, 1'b0, '0, 4'h0, "R9");
        lookup(32'h77, 1'b0, '0, 4'h0, "R3");

        // R4: full queue, push and acknowledge in the same cycle.
        @(negedge clk);
        {st_addr, st_data, st_be} = VEC[4];
        st_valid = 1'b1;
        #1 chk("R4", "ready low before ack", 64'(st_ready), 64'd0);
        chk("R5", "first drain address", 64'(mem_addr), 64'h10);
        mem_ack = 1'b1;
        #1 chk("R4", "ready with ack", 64'(st_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0;
        mem_ack = 1'b0;
        #1 chk("R4", "still full after swap", 64'(st_ready), 64'd0);

        // R9: retired entry no longer forwards.
        lookup(32'h10, 1'b1, 32'h0000_BBBB, 4'h3, "R9");

        // R5 remaining drain order.
        for (int i = 1; i < NV; i++) drain_vec(i);
        #1;
        chk("R7", "req low after last ack", 64'(mem_req), 64'd0);
        chk("R3", "stalled store never drained", 64'(mem_req), 64'd0);
        chk("R1", "ready when drained", 64'(st_ready), 64'd1);
        lookup(32'h50, 1'b0, '0, 4'h0, "R9");

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule